// File: doc/BRIEF.md
# Multi-Page Write Cache Sequencer

This block sits behind a two-wire serial slave in a byte-addressed non-volatile memory. While a write transfer is on the bus, the slave hands each received data byte to the block together with its byte address. The block gathers these bytes into a small cache. The cache has eight lines of eight bytes, and each line is tagged with the page it belongs to. Bytes for a page that already owns a line merge into that line. A new page takes the next free line. Once every line is in use, bytes for further pages are thrown away. A per-byte mask records which bytes were actually loaded.

When the slave has seen the STOP that ends the transfer, it pulses a commit strobe. The block then commits the cached lines to the memory array through a simple write port, one page at a time, in the order in which the lines were allocated. Each page occupies a fixed slot of `PAGE_CYCLES` clocks, which stands in for the self-timed erase-then-program cycle. Only masked bytes are written, so every other byte keeps its old contents. Throughout the commit a busy flag is high, and the slave uses it to withhold acknowledges. The total commit time is the per-page slot multiplied by the number of cached pages. At the end, every line and every mask is cleared.

Top module: `wcache_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` is low and `mem_we` is low.
- R2: A byte written at address A reaches memory at address A with its data unchanged, where the page is A[ADDR_W-1:3] and the offset within the line is A[2:0].
- R3: When the same page and offset are written twice before a commit, the later value replaces the earlier one, and that byte is written to memory only once.
- R4: All bytes of one page share a single line, so a full 8-byte page takes one page slot and produces eight memory writes.
- R5: Distinct pages take lines in the order in which their first byte arrives. The commit writes lines in that order. Within each page slot it issues one write per clock, for ascending offsets 0..7, during the first eight clocks of the slot, and skips offsets that were not loaded.
- R6: Once eight lines are held, a byte for a ninth distinct page is dropped and never reaches memory. Bytes for pages that are already held still merge.
- R7: Only bytes loaded into the cache are written to memory, and every other memory byte keeps its contents. `mem_we` is asserted only while `busy` is high.
- R8: `busy` rises on the clock edge that samples the commit strobe while N ≥ 1 lines are held, and it stays high for exactly N × PAGE_CYCLES clocks.
- R9: Byte writes and commit strobes that arrive while `busy` is high have no effect.
- R10: The end of a commit empties the cache. A commit strobe with an empty cache leaves `busy` low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write into the cache, one byte per asserted clock |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte value |
| commit_req | input | 1 | Single-cycle strobe that starts the commit, issued after STOP |
| mem_we | output | 1 | Memory array write enable |
| mem_addr | output | ADDR_W | Memory array byte address |
| mem_data | output | 8 | Memory array write data |
| busy | output | 1 | Commit in progress; the slave suppresses acknowledges |

## Verification
The commit path is driven with four kinds of load pattern. A single byte shows that address and data pass through unchanged. A full page followed by a rewrite of one offset separates merging from overwriting. A sweep of one to eight pages, with rotating sparse masks and bytes interleaved across the pages, exposes any error in allocation order, in mask handling, or in a commit time that is not proportional to the page count. An overfilled cache with ten pages, plus writes and strobes injected during busy, shows that overflow and busy-time traffic are discarded rather than merged or queued. After each commit the whole memory image is compared, so a write to an untouched byte is caught wherever it lands.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/wc_tag_match.sv
module wc_tag_match #(
  parameter int LINES  = 8,
  parameter int PAGE_W = 9,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic [LINES*PAGE_W-1:0] tags_flat,
  input  logic [CNT_W-1:0]        fill,
  input  logic [PAGE_W-1:0]       page,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx
);
  logic [LINES-1:0] cmp;

  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign cmp[i] = (CNT_W'(i) < fill) &&
                    (tags_flat[i*PAGE_W +: PAGE_W] == page);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (cmp[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wc_line_store.sv
module wc_line_store
  import wc_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 8,
  parameter int PAGE_W     = 9,
  parameter int OFF_W      = 3,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_do,
  input  logic                    wr_alloc,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [PAGE_W-1:0]       wr_page,
  input  logic [OFF_W-1:0]        wr_off,
  input  byte_t                   wr_data,
  input  logic                    clear,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [OFF_W-1:0]        rd_off,
  output logic                    rd_valid,
  output byte_t                   rd_data,
  output logic [PAGE_W-1:0]       rd_tag,
  output logic [LINES*PAGE_W-1:0] tags_flat,
  output logic [CNT_W-1:0]        fill
);
  byte_t                 data_q [LINES][LINE_BYTES];
  logic [PAGE_W-1:0]     tag_q  [LINES];
  logic [LINE_BYTES-1:0] mask_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_flat
    assign tags_flat[i*PAGE_W +: PAGE_W] = tag_q[i];
  end

  // Payload and tags: no reset needed, qualified by masks and fill count.
  always_ff @(posedge clk) begin
    if (wr_do) data_q[wr_idx][wr_off] <= wr_data;
    if (wr_alloc) tag_q[wr_idx] <= wr_page;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < LINES; i++) mask_q[i] <= '0;
      fill <= '0;
    end else if (wr_do) begin
      mask_q[wr_idx][wr_off] <= 1'b1;
      if (wr_alloc) fill <= fill + CNT_W'(1);
    end
  end

  assign rd_valid = mask_q[rd_idx][rd_off];
  assign rd_data  = data_q[rd_idx][rd_off];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wc_commit_fsm.sv
module wc_commit_fsm #(
  parameter int PAGE_CYCLES = 16,
  parameter int LINE_BYTES  = 8,
  parameter int OFF_W       = 3,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] fill,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic [OFF_W-1:0] tick_off,
  output logic             prog_phase,
  output logic             page_done,
  output logic             commit_end
);
  localparam int TICK_W = $clog2(PAGE_CYCLES + 1);

  logic [TICK_W-1:0] tick;
  logic              last_line;

  assign last_line  = (CNT_W'(cur_idx) + CNT_W'(1)) == fill;
  assign page_done  = busy && (tick == TICK_W'(PAGE_CYCLES - 1));
  assign commit_end = page_done && last_line;
  assign prog_phase = busy && (tick < TICK_W'(LINE_BYTES));
  assign tick_off   = OFF_W'(tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_idx <= '0;
      tick    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        cur_idx <= '0;
        tick    <= '0;
      end
    end else if (page_done) begin
      if (last_line) begin
        busy <= 1'b0;
      end else begin
        cur_idx <= cur_idx + IDX_W'(1);
        tick    <= '0;
      end
    end else begin
      tick <= tick + TICK_W'(1);
    end
  end
endmodule

// File: rtl/wcache_seq.sv
module wcache_seq
  import wc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int LINES       = 8,
  parameter int LINE_BYTES  = 8,
  parameter int PAGE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              commit_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              busy
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int CNT_W  = $clog2(LINES + 1);

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] p,
                                                  input logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  // Named internal events for the checker.
  logic                    accept, wr_hit, wr_alloc, wr_drop, wr_do;
  logic                    commit_start, commit_end, page_done, prog_phase;
  logic [CNT_W-1:0]        fill;
  logic [IDX_W-1:0]        hit_idx, wr_idx, cur_idx;
  logic [OFF_W-1:0]        tick_off;
  logic                    hit, rd_valid;
  logic [PAGE_W-1:0]       rd_tag;
  byte_t                   rd_data;
  logic [LINES*PAGE_W-1:0] tags_flat;
  logic                    cache_full;

  assign cache_full   = (fill == CNT_W'(LINES));
  assign accept       = wr_en && !busy;
  assign wr_hit       = accept && hit;
  assign wr_alloc     = accept && !hit && !cache_full;
  assign wr_drop      = accept && !hit && cache_full;
  assign wr_do        = wr_hit || wr_alloc;
  assign wr_idx       = hit ? hit_idx : IDX_W'(fill);
  assign commit_start = commit_req && !busy && (fill != '0);

  wc_tag_match #(
    .LINES(LINES), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_match (
    .tags_flat (tags_flat),
    .fill      (fill),
    .page      (page_of(wr_addr)),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  wc_line_store #(
    .LINES(LINES), .LINE_BYTES(LINE_BYTES), .PAGE_W(PAGE_W),
    .OFF_W(OFF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_do     (wr_do),
    .wr_alloc  (wr_alloc),
    .wr_idx    (wr_idx),
    .wr_page   (page_of(wr_addr)),
    .wr_off    (offset_of(wr_addr)),
    .wr_data   (wr_data),
    .clear     (commit_end),
    .rd_idx    (cur_idx),
    .rd_off    (tick_off),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_tag    (rd_tag),
    .tags_flat (tags_flat),
    .fill      (fill)
  );

  wc_commit_fsm #(
    .PAGE_CYCLES(PAGE_CYCLES), .LINE_BYTES(LINE_BYTES),
    .OFF_W(OFF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (commit_start),
    .fill       (fill),
    .busy       (busy),
    .cur_idx    (cur_idx),
    .tick_off   (tick_off),
    .prog_phase (prog_phase),
    .page_done  (page_done),
    .commit_end (commit_end)
  );

  assign mem_we   = prog_phase && rd_valid;
  assign mem_addr = join_addr(rd_tag, tick_off);
  assign mem_data = rd_data;
endmodule

// File: rtl/wcache_seq_chk.sv
module wcache_seq_chk #(
  parameter int LINES = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_we,
  input logic             commit_req,
  input logic             commit_start,
  input logic             commit_end,
  input logic             wr_drop,
  input logic [CNT_W-1:0] fill
);
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R7
  AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> busy); // R8
  AST_EMPTY_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit_req && fill == '0) |=> !busy); // R10
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_end) |=> $stable(fill)); // R9
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> (fill == CNT_W'(LINES))); // R6
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(LINES)); // R6
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_end |=> (fill == '0 && !busy)); // R10
endmodule

bind wcache_seq wcache_seq_chk #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .mem_we       (mem_we),
  .commit_req   (commit_req),
  .commit_start (commit_start),
  .commit_end   (commit_end),
  .wr_drop      (wr_drop),
  .fill         (fill)
);

// File: tb/wcache_seq_bench.sv
module wcache_seq_bench;
  localparam int AW = 12;
  localparam int PC = 12;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          commit_req = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic          busy;

  int n_chk = 0;
  int n_bad = 0;

  wcache_seq #(.ADDR_W(AW), .LINES(8), .LINE_BYTES(8), .PAGE_CYCLES(PC)) u_wcache_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy)
  );

  always #10 clk = ~clk;

  // Memory model and write log, sampled on the falling edge.
  logic [7:0] mem [MSZ];
  logic [7:0] expmem [MSZ];
  int         wla [128];
  int         wld [128];
  int         wlog_n = 0;

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (wlog_n < 128) begin
        wla[wlog_n] = int'(mem_addr);
        wld[wlog_n] = int'(mem_data);
      end
      wlog_n++;
      mem[mem_addr] = mem_data;
    end
  end

  // Reference cache state, built from the requirements.
  int         mcnt = 0;
  logic [8:0] mtag [8];
  logic [7:0] mdat [8][8];
  logic [7:0] mmask [8];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_wr(input logic [AW-1:0] a, input logic [7:0] d);
    int idx = -1;
    for (int i = 0; i < mcnt; i++) if (mtag[i] == a[AW-1:3]) idx = i;
    if (idx < 0 && mcnt < 8) begin
      idx = mcnt;
      mtag[idx] = a[AW-1:3];
      mmask[idx] = '0;
      mcnt++;
    end
    if (idx >= 0) begin
      mdat[idx][a[2:0]] = d;
      mmask[idx][a[2:0]] = 1'b1;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_commit(input string req, input bit inject);
    int ea [64];
    int ed [64];
    int nexp = 0;
    int n = 0;
    int bad = 0;
    for (int i = 0; i < mcnt; i++)
      for (int o = 0; o < 8; o++)
        if (mmask[i][o]) begin
          ea[nexp] = int'({mtag[i], 3'(o)});
          ed[nexp] = int'(mdat[i][o]);
          nexp++;
        end
    wlog_n = 0;
    @(negedge clk);
    chk("R8", "busy before strobe", int'(busy), 0);
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    chk((mcnt == 0) ? "R10" : "R8", "busy one clock after strobe", int'(busy), (mcnt > 0) ? 1 : 0);
    while (busy && n < 20000) begin
      n++;
      if (inject && n == 3) begin
        wr_en = 1'b1; wr_addr = 12'h7F8; wr_data = 8'hEE; commit_req = 1'b1;  // R9 stimulus
      end else begin
        wr_en = 1'b0; commit_req = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0; commit_req = 1'b0;
    chk("R8", "busy length in clocks", n, mcnt * PC);
    chk(req, "memory write count", wlog_n, nexp);
    for (int k = 0; k < nexp && k < wlog_n; k++) begin
      chk("R5", "write address in order", wla[k], ea[k]);
      chk("R2", "write data", wld[k], ed[k]);
    end
    for (int k = 0; k < nexp; k++) expmem[ea[k]] = 8'(ed[k]);
    for (int a = 0; a < MSZ; a++) if (mem[a] !== expmem[a]) bad++;
    chk("R7", "memory bytes differing from expected image", bad, 0);
    mcnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < MSZ; a++) begin
      mem[a] = 8'(a) ^ 8'h5A;
      expmem[a] = 8'(a) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "mem_we after reset", int'(mem_we), 0);

    // R10: strobe with an empty cache
    do_commit("R10", 1'b0);

    // R2: single byte
    wr(12'h123, 8'hC7);
    do_commit("R2", 1'b0);

    // R4 full page, then R3 rewrite of one offset
    for (int o = 0; o < 8; o++) wr(12'h0A8 + 12'(o), 8'(8'h10 + o));
    wr(12'h0AD, 8'h99);
    do_commit("R4", 1'b0);
    wr(12'h345, 8'h01);
    wr(12'h345, 8'h02);
    do_commit("R3", 1'b0);

    // R5/R7 sweep: one to eight pages, sparse rotating masks, interleaved bytes
    for (int r = 0; r < 8; r++) begin
      for (int o = 0; o < 8; o++)
        for (int k = 0; k <= r; k++) begin
          logic [7:0] pm;
          logic [8:0] pg;
          pm = 8'b1011_0110;
          pm = (pm << ((k + r) % 8)) | (pm >> (8 - (k + r) % 8));
          pg = 9'((r * 37 + k * 13 + 5) % 512);
          if (pm[o]) wr({pg, 3'(o)}, 8'((r * 64 + k * 8 + o) ^ 8'h3C));
        end
      do_commit("R5", 1'b0);
    end

    // R6: ten pages, the last two dropped; a held page still merges
    for (int k = 0; k < 10; k++) wr(12'(k * 40 + 8 + (k % 8)), 8'(8'hA0 + k));
    wr(12'(0 * 40 + 8 + 3), 8'h77);
    chk("R6", "reference lines held", mcnt, 8);
    do_commit("R6", 1'b0);

    // R9: traffic injected during busy, then an empty strobe must do nothing
    wr(12'h200, 8'h42);
    wr(12'h20F, 8'h43);
    do_commit("R9", 1'b1);
    do_commit("R9", 1'b0);
    chk("R9", "memory at injected address", int'(mem[12'h7F8]), int'(expmem[12'h7F8]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule